// File: doc/BRIEF.md
# Double-Buffered SPI Peripheral Core

This block is a byte-wide SPI peripheral for a CPU register bus. It works as master or slave. In master mode it generates the serial clock and starts a transfer when the CPU writes the data register. In slave mode the same write only preloads the outgoing byte, and the remote master supplies the clock while it holds the active-low select.

Outgoing data has one stage: a data write goes straight into the shift register. Incoming data has two stages: when a byte completes, the shift register hands it to a separate read buffer, and the CPU reads that buffer. A completion flag marks each finished byte. If a byte completes while that flag is still set, the block reports an overrun and keeps the byte that is already buffered. A write that arrives during a transfer is dropped and reported as a collision.

The CPU sees three registers, chosen by `bus_addr`:
- Address 0 is data.
- Address 1 is control. Bit 0 selects master. Bit 1 is the clock idle level. Bit 2 is the clock phase. Bit 3 selects LSB first. Bits 6:4 are the rate. Bit 7 is spare and reads back as written.
- Address 2 is status. Bit 7 is done, bit 6 is collision and bit 5 is overrun.

Top module: `spi_dbuf_core`

## Requirements
- R1: In master mode (control bit 0 = 1), a data write while idle starts a transfer of 16 serial-clock edges. In slave mode the write only loads the outgoing byte, and no transfer starts without a remote clock.
- R2: After the 8th bit of a transfer, status bit 7 (done) is set. This holds in both master and slave mode.
- R3: A data-register read returns the read buffer, which holds the last byte received. The outgoing byte does not appear there.
- R4: If done is still set when another byte completes, status bit 5 (overrun) is set and the read buffer keeps its earlier byte.
- R5: Two steps clear done, overrun and collision together. First, read status while any of them is set. Then access the data register. A data access without that prior status read clears nothing.
- R6: Control bit 3 = 1 sends and receives LSB first. Control bit 3 = 0 sends and receives MSB first.
- R7: Control bits 6:4 set the rate. Bits 5:4 give a ratio of 2, 4, 16 or 32, and bit 6 multiplies that ratio by 4. A master transfer lasts 8 × ratio system clocks.
- R8: The serial clock idles at control bit 1. With control bit 2 = 0, data is sampled on the leading edge of each bit. With control bit 2 = 1, it is sampled on the trailing edge.
- R9: A data write during a transfer is ignored and sets status bit 6 (collision). In slave mode, a transfer counts as running whenever the select is low.
- R10: In slave mode with the select high, MISO output-enable is low, serial-clock edges are ignored and the bit counter is reset.
- R11: After reset, the status and control registers read 0. The block then idles as a slave with clock idle level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (has side effects on status) |
| bus_addr | input | 2 | 0 data, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master serial data out |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master serial data in |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
Master transfers run in loopback with MOSI fed back to MISO. The bytes are asymmetric, so a monitor that captures MOSI on the sampling edges can distinguish MSB-first from LSB-first shifting and leading-edge from trailing-edge phase. Several rate codes, including ones that use the extension bit, are timed from the write to the done flag, which exposes a wrong divider ratio. Two back-to-back transfers without a clear show whether the buffer keeps the first byte. A slave run with stray clock edges while the select is high, a preloaded byte and a write in mid-byte covers slave loading, the counter reset, output-enable and collision.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int HALF_W = 7;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic       spare;
    logic [2:0] rate;
    logic       lsb_first;
    logic       cpha;
    logic       cpol;
    logic       master;
  } ctrl_t;

  // system clocks per serial-clock half period
  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] rate);
    logic [HALF_W-1:0] b;
    case (rate[1:0])
      2'd0:    b = 7'd1;
      2'd1:    b = 7'd2;
      2'd2:    b = 7'd8;
      default: b = 7'd16;
    endcase
    return rate[2] ? (b << 2) : b;
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  a_r7_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half != 1 && $stable(half)) |=> !tick);
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsbf,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          m_tick,
  input  logic          s_edge,
  input  logic          s_clear,
  input  logic          sdi,
  output logic          sdo,
  output logic          sck_lvl,
  output logic          running,
  output logic          xfer_end,
  output logic [DW-1:0] rx_byte
);
  localparam int IW = $clog2(2 * DW);
  localparam logic [IW-1:0] LAST = IW'(2 * DW - 1);

  logic [DW-1:0] shreg;
  logic [IW-1:0] idx;
  logic          tog, in_bit;
  logic          step, sample_now, shift_now, new_bit;

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] v,
                                             input logic b, input logic lf);
    return lf ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  assign step       = master ? m_tick : s_edge;
  assign sample_now = (idx[0] == cpha);
  assign shift_now  = (!sample_now && !(cpha && idx == '0)) || (idx == LAST);
  assign new_bit    = sample_now ? sdi : in_bit;
  assign xfer_end   = step && (idx == LAST);
  assign rx_byte    = shift_in(shreg, new_bit, lsbf);
  assign sdo        = lsbf ? shreg[0] : shreg[DW-1];
  assign sck_lvl    = cpol ^ tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; idx <= '0; tog <= 1'b0; in_bit <= 1'b0; running <= 1'b0;
    end else begin
      if (load) shreg <= load_val;
      if (load && master) running <= 1'b1;
      if (step) begin
        idx <= (idx == LAST) ? '0 : idx + 1'b1;
        tog <= ~tog;
        if (sample_now) in_bit <= sdi;
        if (shift_now)  shreg  <= shift_in(shreg, new_bit, lsbf);
        if (xfer_end)   running <= 1'b0;
      end
      if (!master && s_clear) begin
        idx <= '0; tog <= 1'b0;
      end
    end
  end

  a_r10_idx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && s_clear) |=> (idx == '0));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !running) |-> !step);
  a_r8_clock_home: assert property (@(posedge clk) disable iff (!rst_n)
    (master && xfer_end && !load) |=> (sck_lvl == cpol));
endmodule

// File: rtl/spi_dbuf_core.sv
module spi_dbuf_core
  import spi_dbuf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_o,
  input  logic          sck_i,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i,
  input  logic          ss_n_i
);
  localparam int CTW = $bits(ctrl_t);

  ctrl_t         ctrl;
  logic [DW-1:0] rxbuf, rx_byte;
  logic          done, ovr, coll, armed;
  logic [1:0]    sck_sy, mosi_sy, ss_sy;
  logic          sck_q;
  logic          data_wr, data_rd, ctrl_wr, stat_rd, data_acc;
  logic          busy, load, coll_set, clr;
  logic          m_tick, s_edge, sdo, sck_lvl, running, xfer_end;
  logic          ss_s, sck_s, mosi_s;

  assign data_wr  = bus_sel && bus_wr && (bus_addr == REG_DATA);
  assign data_rd  = bus_sel && bus_rd && (bus_addr == REG_DATA);
  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == REG_CTRL);
  assign stat_rd  = bus_sel && bus_rd && (bus_addr == REG_STAT);
  assign data_acc = data_wr || data_rd;

  assign ss_s   = ss_sy[1];
  assign sck_s  = sck_sy[1];
  assign mosi_s = mosi_sy[1];

  assign busy     = ctrl.master ? running : !ss_s;
  assign load     = data_wr && !busy;
  assign coll_set = data_wr && busy;
  assign clr      = armed && data_acc;
  assign s_edge   = !ctrl.master && !ss_s && (sck_s ^ sck_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0; mosi_sy <= '0; ss_sy <= '1; sck_q <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
      sck_q   <= sck_s;
    end
  end

  spi_clk_div #(.CW(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running && ctrl.master),
    .half(half_period(ctrl.rate)), .tick(m_tick)
  );

  spi_shift_eng #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .master(ctrl.master), .cpol(ctrl.cpol),
    .cpha(ctrl.cpha), .lsbf(ctrl.lsb_first), .load(load), .load_val(bus_wdata),
    .m_tick(m_tick), .s_edge(s_edge), .s_clear(ss_s),
    .sdi(ctrl.master ? miso_i : mosi_s), .sdo(sdo), .sck_lvl(sck_lvl),
    .running(running), .xfer_end(xfer_end), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; done <= 1'b0; ovr <= 1'b0; coll <= 1'b0; armed <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[CTW-1:0]);
      if (stat_rd && (done || ovr || coll)) armed <= 1'b1;
      else if (clr)                         armed <= 1'b0;
      if (xfer_end)  done <= 1'b1;
      else if (clr)  done <= 1'b0;
      if (xfer_end && done) ovr <= 1'b1;
      else if (clr)         ovr <= 1'b0;
      if (coll_set)  coll <= 1'b1;
      else if (clr)  coll <= 1'b0;
    end
  end

  // read buffer has no reset value
  always_ff @(posedge clk) begin
    if (xfer_end && !done) rxbuf <= rx_byte;
  end

  always_comb begin
    case (bus_addr)
      REG_DATA: bus_rdata = rxbuf;
      REG_CTRL: bus_rdata = DW'(ctrl);
      REG_STAT: bus_rdata = {done, coll, ovr, {(DW-3){1'b0}}};
      default:  bus_rdata = '0;
    endcase
  end

  assign sck_o   = ctrl.master ? sck_lvl : ctrl.cpol;
  assign mosi_o  = ctrl.master ? sdo : 1'b0;
  assign miso_o  = sdo;
  assign miso_oe = !ctrl.master && !ss_n_i;

  a_r2_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done);
  a_r4_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && done) |=> (ovr && rxbuf == $past(rxbuf)));
  a_r5_clear_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !xfer_end && !coll_set) |=> (!done && !ovr && !coll));
  a_r9_coll_flag: assert property (@(posedge clk) disable iff (!rst_n)
    coll_set |=> coll);
  a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n_i || ctrl.master) |-> !miso_oe);
endmodule

// File: tb/spi_dbuf_core_tb.sv
module spi_dbuf_core_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 2'd2;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sck_o, sck_i = 0, mosi_o, mosi_i = 0, miso_o, miso_oe, miso_i;
  logic       ss_n_i = 1'b1;

  int n_chk = 0, n_err = 0, wd = 0;
  logic       cur_cpol = 0, cur_cpha = 0, prev_sck = 0, prev_mosi = 0;
  logic [7:0] cap = '0, rd_val;
  int         sck_edges = 0;

  always #4 clk = ~clk;
  assign miso_i = mosi_o;

  spi_dbuf_core u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  // MOSI monitor on the sampling edge of the master clock
  always @(negedge clk) begin
    if (sck_o !== prev_sck) begin
      sck_edges++;
      if ((prev_sck == cur_cpol) != cur_cpha) cap = {cap[6:0], prev_mosi};
    end
    prev_sck  = sck_o;
    prev_mosi = mosi_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = 2'd2;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_rd = 0; bus_addr = 2'd2;
  endtask

  task automatic peek_stat(output logic [7:0] d);
    bus_addr = 2'd2;
    #1 d = bus_rdata;
  endtask

  function automatic int ratio_of(input logic [2:0] r);
    int base;
    base = 2 << r[1:0];
    if (r[1:0] >= 2) base = base * 2;
    return r[2] ? base * 4 : base;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = v[7-i];
    return o;
  endfunction

  // clear flags: status read then data read; returns the data byte
  task automatic clear_and_read(output logic [7:0] d);
    logic [7:0] s;
    bus_read(2'd2, s);
    bus_read(2'd0, d);
  endtask

  // one master transfer with loopback; checks timing, order and buffer
  task automatic master_xfer(input string tag, input logic [7:0] ctrlv, input logic [7:0] b);
    logic [7:0] s, d;
    int cyc;
    cur_cpol = ctrlv[1]; cur_cpha = ctrlv[2];
    bus_write(2'd1, ctrlv);
    repeat (2) @(negedge clk);
    cap = '0; sck_edges = 0;
    bus_write(2'd0, b);
    cyc = 1;
    peek_stat(s);
    while (!s[7] && cyc < 5000) begin
      @(negedge clk); cyc++; peek_stat(s);
    end
    chk({tag, " R7 transfer length"}, cyc, 8 * ratio_of(ctrlv[6:4]) + 1);
    chk({tag, " R2 done set"}, s[7], 1);
    chk({tag, " R8 sixteen clock edges"}, sck_edges, 16);
    chk({tag, " R8 clock idles at polarity"}, sck_o, ctrlv[1]);
    chk({tag, " R6 bit order on MOSI"}, cap, ctrlv[3] ? rev8(b) : b);
    clear_and_read(d);
    chk({tag, " R3 read buffer holds received byte"}, d, b);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek_stat(d);
    chk("R11 status after reset", d, 0);
    bus_read(2'd1, d);
    chk("R11 control after reset", d, 0);
    chk("R11 clock idle low", sck_o, 0);
    chk("R10 no output enable after reset", miso_oe, 0);
  endtask

  task automatic t_clear_seq;
    logic [7:0] s, d;
    master_xfer("clr", 8'h01, 8'h6B);
    bus_write(2'd0, 8'h2D);
    repeat (40) @(negedge clk);
    bus_read(2'd0, d);
    peek_stat(s);
    chk("R5 data access alone keeps done", s[7], 1);
    chk("R3 buffer holds second byte", d, 8'h2D);
    clear_and_read(d);
    peek_stat(s);
    chk("R5 sequence clears status", s, 0);
  endtask

  task automatic t_overrun;
    logic [7:0] s, d;
    bus_write(2'd1, 8'h01); cur_cpol = 0; cur_cpha = 0;
    bus_write(2'd0, 8'h3C);
    repeat (40) @(negedge clk);
    bus_write(2'd0, 8'hA5);
    repeat (40) @(negedge clk);
    peek_stat(s);
    chk("R4 overrun and done set", s, 8'hA0);
    clear_and_read(d);
    chk("R4 buffer keeps first byte", d, 8'h3C);
    peek_stat(s);
    chk("R5 overrun cleared by sequence", s, 0);
  endtask

  task automatic t_collision;
    logic [7:0] s, d;
    bus_write(2'd1, 8'h21); cur_cpol = 0; cur_cpha = 0;
    cap = '0;
    bus_write(2'd0, 8'h96);
    repeat (3) @(negedge clk);
    bus_write(2'd0, 8'h0F);
    peek_stat(s);
    chk("R9 collision flag", s[6], 1);
    repeat (200) @(negedge clk);
    chk("R9 first byte sent unchanged", cap, 8'h96);
    clear_and_read(d);
    chk("R9 received first byte", d, 8'h96);
    peek_stat(s);
    chk("R5 collision cleared", s, 0);
  endtask

  task automatic t_slave;
    logic [7:0] s, d, got;
    logic [7:0] tx = 8'h5A;
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'hC3);
    repeat (4) begin
      @(negedge clk); sck_i = ~sck_i; repeat (6) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    peek_stat(s);
    chk("R1 slave write starts nothing", s[7], 0);
    chk("R10 MISO disabled while deselected", miso_oe, 0);
    ss_n_i = 0;
    repeat (6) @(negedge clk);
    chk("R10 MISO enabled when selected", miso_oe, 1);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      mosi_i = tx[7-i];
      repeat (6) @(negedge clk);
      got = {got[6:0], miso_o};
      sck_i = 1;
      repeat (6) @(negedge clk);
      if (i == 3) bus_write(2'd0, 8'hFF);
      sck_i = 0;
    end
    repeat (8) @(negedge clk);
    chk("R1 slave sends preloaded byte", got, 8'hC3);
    peek_stat(s);
    chk("R2 slave done and R9 collision", s, 8'hC0);
    clear_and_read(d);
    chk("R3 slave received byte", d, tx);
    ss_n_i = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    master_xfer("m0", 8'h01, 8'hB1);
    master_xfer("m3lsb", 8'h1F, 8'h1E);
    master_xfer("m1", 8'h45, 8'hC8);
    master_xfer("m_ext", 8'h6B, 8'h4E);
    t_clear_seq();
    t_overrun();
    t_collision();
    t_slave();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule